// File: doc/BRIEF.md
# Calibration Command Sequencer

This block sits in the control logic of a sampled data converter and decides when calibration runs. A calibration request arrives on one of two sources: a dedicated pin or a software-written register bit. A selector input picks the source, and both sources follow the same rule. A request counts only after the chosen source has been low for a minimum number of sample-clock cycles and then high for a minimum number of cycles. The register bit never clears itself. It may stay high indefinitely, and a new calibration needs a new low-then-high sequence.

An accepted request starts a two-phase sequence. The first phase is an optional termination-trim phase, during which the output data clock is held off. The second phase is a mandatory bias-calibration phase. Each phase lasts a fixed number of cycles, set by a parameter. A done strobe from a phase timer ends it. While the sequence runs, a busy flag is high, output data is marked invalid, and the out-of-range flag is forced low.

The sequence also runs once after reset as a power-up calibration. Three qualifiers can hold off or block a start. Power-down blocks any start. When clock phase adjust is on, a start is allowed only if the trim-disable bit is set. Requests that arrive while calibration runs are dropped.

Top module: `cal_seq_top`

## Requirements
- R1: A calibration starts only after the selected request source is sampled low on at least LOW_MIN consecutive clock edges and then high on HIGH_MIN consecutive edges. `busy` goes high right after the HIGH_MIN-th high edge. A low level that ends early, or a high level that ends early, starts nothing.
- R2: `src_sel`=0 selects `req_pin` and `src_sel`=1 selects `req_reg`. The source that is not selected has no effect. A selected source that stays high after a start does not start a second calibration.
- R3: With `trim_dis`=0 the trim phase lasts TRIM_CYC cycles and the bias phase follows. With `trim_dis`=1 the trim phase is skipped. The bias phase always lasts BIAS_CYC cycles, so `busy` is high for TRIM_CYC+BIAS_CYC or BIAS_CYC cycles.
- R4: If `cpa_en`=1 and `trim_dis`=0 when a request qualifies, the request is ignored. If `cpa_en`=0, `trim_dis` does not decide whether calibration starts.
- R5: A request that qualifies while `pwr_down`=1 is ignored.
- R6: `busy` is high for the whole sequence, both for on-command calibrations and for the power-up calibration. The power-up calibration's `busy` goes high after the third clock edge following the release of `rst_n`.
- R7: `dclk_en` is low exactly during the trim phase. That is the first TRIM_CYC cycles of `busy`, and no cycles when the trim phase is skipped.
- R8: While `busy` is high, `data_valid` is 0 and `or_flag` is 0. While idle, `data_valid` is 1 and `or_flag` follows `or_raw`.
- R9: Request edges during `busy` are ignored. Qualification starts from zero when calibration ends.
- R10: The power-up calibration waits while `pwr_down`=1 and starts on the first edge after `pwr_down` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_pin | input | 1 | Calibration request from the pin |
| req_reg | input | 1 | Calibration request from the register bit |
| src_sel | input | 1 | 0: pin request, 1: register request |
| trim_dis | input | 1 | Skip the termination-trim phase |
| cpa_en | input | 1 | Clock phase adjust enabled |
| pwr_down | input | 1 | Converter in power-down |
| or_raw | input | 1 | Raw out-of-range indication |
| busy | output | 1 | Calibration running |
| dclk_en | output | 1 | Output data clock enable, low during trim |
| data_valid | output | 1 | Output data valid |
| or_flag | output | 1 | Out-of-range flag, masked during calibration |

## Verification
The request qualifier is driven with random pairs of low and high lengths on either source. Some pairs fall just short of LOW_MIN or HIGH_MIN, and others meet or exceed them, which shows whether the thresholds are applied inclusively and in the right order. Those pairs are combined with random settings of trim-disable, clock phase adjust and power-down. A start, its cycle, the busy length and the count of gated clock cycles together tell a skipped trim phase from a blocked request and from a power-down rejection. Directed cases toggle the unselected source, keep the selected source high after a start, replay a full request during busy, and hold power-down across reset, so that each ignore rule shows up at the outputs.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_TRIM = 2'd1,
    CS_BIAS = 2'd2
  } cal_state_e;
endpackage

// File: rtl/cal_req_qual.sv
// Qualifies a request as LOW_MIN low samples followed by HIGH_MIN high samples.
module cal_req_qual #(
  parameter int LOW_MIN  = 4,
  parameter int HIGH_MIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic req,
  output logic fire
);
  localparam int LW = $clog2(LOW_MIN + 1);
  localparam int HW = $clog2(HIGH_MIN + 1);

  logic [LW-1:0] lo_cnt, lo_nxt;
  logic [HW-1:0] hi_cnt, hi_nxt;
  logic          armed, armed_nxt;

  assign fire = req & armed & ~clr & (hi_cnt == HW'(HIGH_MIN - 1));

  always_comb begin
    lo_nxt    = lo_cnt;
    hi_nxt    = hi_cnt;
    armed_nxt = armed;
    if (clr) begin
      lo_nxt    = '0;
      hi_nxt    = '0;
      armed_nxt = 1'b0;
    end else if (!req) begin
      hi_nxt    = '0;
      if (lo_cnt != LW'(LOW_MIN)) lo_nxt = lo_cnt + 1'b1;
      armed_nxt = (lo_nxt == LW'(LOW_MIN));
    end else begin
      lo_nxt = '0;
      if (fire) begin
        hi_nxt    = '0;
        armed_nxt = 1'b0;
      end else if (armed) begin
        hi_nxt = hi_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
      armed  <= 1'b0;
    end else begin
      lo_cnt <= lo_nxt;
      hi_cnt <= hi_nxt;
      armed  <= armed_nxt;
    end
  end
endmodule

// File: rtl/cal_phase_timer.sv
// Fixed-length phase model: done strobes on the DUR-th cycle of run.
module cal_phase_timer #(
  parameter int DUR = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(DUR + 1);

  logic [CW-1:0] cnt, cnt_nxt;

  assign done = run & (cnt == CW'(DUR - 1));

  always_comb begin
    if (!run || done) cnt_nxt = '0;
    else              cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/cal_seq_top.sv
module cal_seq_top #(
  parameter int LOW_MIN   = 4,
  parameter int HIGH_MIN  = 3,
  parameter int TRIM_CYC  = 12,
  parameter int BIAS_CYC  = 20,
  parameter bit PWRUP_CAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_pin,
  input  logic req_reg,
  input  logic src_sel,
  input  logic trim_dis,
  input  logic cpa_en,
  input  logic pwr_down,
  input  logic or_raw,
  output logic busy,
  output logic dclk_en,
  output logic data_valid,
  output logic or_flag
);
  import cal_seq_pkg::*;

  logic [1:0]  rst_q;
  logic        srst_n;
  cal_state_e  state, state_nxt;
  logic        pend, pend_nxt;
  logic        req_sel, fire, allowed, start;
  logic        trim_done, bias_done;

  // Reset: asserted asynchronously, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign srst_n = rst_q[1];

  assign req_sel = src_sel ? req_reg : req_pin;

  cal_req_qual #(.LOW_MIN(LOW_MIN), .HIGH_MIN(HIGH_MIN)) u_qual (
    .clk  (clk),
    .rst_n(srst_n),
    .clr  (busy),
    .req  (req_sel),
    .fire (fire)
  );

  cal_phase_timer #(.DUR(TRIM_CYC)) u_trim_tmr (
    .clk  (clk),
    .rst_n(srst_n),
    .run  (state == CS_TRIM),
    .done (trim_done)
  );

  cal_phase_timer #(.DUR(BIAS_CYC)) u_bias_tmr (
    .clk  (clk),
    .rst_n(srst_n),
    .run  (state == CS_BIAS),
    .done (bias_done)
  );

  assign allowed = ~pwr_down & (~cpa_en | trim_dis);
  assign start   = (fire | pend) & allowed & (state == CS_IDLE);

  always_comb begin
    state_nxt = state;
    pend_nxt  = pend & ~start;
    unique case (state)
      CS_IDLE: if (start) state_nxt = trim_dis ? CS_BIAS : CS_TRIM;
      CS_TRIM: if (trim_done) state_nxt = CS_BIAS;
      CS_BIAS: if (bias_done) state_nxt = CS_IDLE;
      default: state_nxt = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state <= CS_IDLE;
      pend  <= PWRUP_CAL;
    end else begin
      state <= state_nxt;
      pend  <= pend_nxt;
    end
  end

  assign busy       = (state != CS_IDLE);
  assign dclk_en    = (state != CS_TRIM);
  assign data_valid = ~busy;
  assign or_flag    = or_raw & ~busy;
endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk #(
  parameter int TRIM_CYC = 12,
  parameter int BIAS_CYC = 20
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic dclk_en,
  input logic data_valid,
  input logic or_flag,
  input logic pwr_down,
  input logic cpa_en,
  input logic trim_dis
);
  logic [15:0] blen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    blen <= '0;
    else if (busy) blen <= blen + 1'b1;
    else           blen <= '0;
  end

  a_r5_no_start_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(pwr_down));

  a_r4_cpa_needs_trim_dis: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!$past(cpa_en) || $past(trim_dis)));

  a_r7_gate_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !dclk_en |-> busy);

  a_r8_outputs_masked: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!or_flag && !data_valid));

  a_r3_skip_trim: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && $past(trim_dis)) |-> dclk_en);

  a_r3_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (blen == 16'(BIAS_CYC) || blen == 16'(TRIM_CYC + BIAS_CYC)));
endmodule

bind cal_seq_top cal_seq_chk #(.TRIM_CYC(TRIM_CYC), .BIAS_CYC(BIAS_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .dclk_en   (dclk_en),
  .data_valid(data_valid),
  .or_flag   (or_flag),
  .pwr_down  (pwr_down),
  .cpa_en    (cpa_en),
  .trim_dis  (trim_dis)
);

// File: tb/cal_seq_top_tb_top.sv
module cal_seq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LOW_MIN    = 4;
  localparam int HIGH_MIN   = 3;
  localparam int TRIM_CYC   = 12;
  localparam int BIAS_CYC   = 20;

  logic clk, rst_n, req_pin, req_reg, src_sel, trim_dis, cpa_en, pwr_down, or_raw;
  logic busy, dclk_en, data_valid, or_flag;
  int   checks = 0;
  int   errors = 0;
  bit   done_flag = 0;

  cal_seq_top #(.LOW_MIN(LOW_MIN), .HIGH_MIN(HIGH_MIN), .TRIM_CYC(TRIM_CYC),
                .BIAS_CYC(BIAS_CYC), .PWRUP_CAL(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_pin(req_pin), .req_reg(req_reg),
    .src_sel(src_sel), .trim_dis(trim_dis), .cpa_en(cpa_en), .pwr_down(pwr_down),
    .or_raw(or_raw), .busy(busy), .dclk_en(dclk_en), .data_valid(data_valid),
    .or_flag(or_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit exp_fire(int l, int h, bit td, bit cpa, bit pd);
    return (l >= LOW_MIN) && (h >= HIGH_MIN) && !pd && (!cpa || td);
  endfunction
  function automatic int exp_len(bit td);
    return td ? BIAS_CYC : TRIM_CYC + BIAS_CYC;
  endfunction
  function automatic int exp_gate(bit td);
    return td ? 0 : TRIM_CYC;
  endfunction

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // Measures a running calibration from the first negedge busy is seen.
  task automatic measure(bit td, string rq);
    int len = 0, gate = 0, bad = 0;
    while (busy) begin
      len++;
      if (!dclk_en) begin gate++; if (len > exp_gate(td)) bad++; end
      if (data_valid || or_flag) bad++;
      or_raw = 1'($urandom % 2);
      @(negedge clk);
    end
    chk(len == exp_len(td), {rq, " R3 R6 busy length"}, len, exp_len(td));
    chk(gate == exp_gate(td) && bad == 0, {rq, " R7 trim gating"}, gate, exp_gate(td));
    chk(bad == 0, {rq, " R8 masking"}, bad, 0);
    or_raw = 1'b1; #1;
    chk(or_flag && data_valid, "R8 idle pass-through", int'(or_flag), 1);
  endtask

  task automatic idle_quiet(int n, string rq);
    int seen = 0;
    repeat (n) begin @(negedge clk); if (busy) seen++; end
    chk(seen == 0, rq, seen, 0);
  endtask

  task automatic trial(int l, int h, bit src, bit td, bit cpa, bit pd);
    bit    ef;
    int    ks = 0;
    string rq;
    ef = exp_fire(l, h, td, cpa, pd);
    rq = pd ? "R5" : ((cpa && !td) ? "R4" : "R1");
    trim_dis = td; cpa_en = cpa; pwr_down = pd; src_sel = src;
    if (src) begin req_reg = 1'b0; req_pin = 1'($urandom % 2); end
    else     begin req_pin = 1'b0; req_reg = 1'($urandom % 2); end
    repeat (l) @(negedge clk);
    if (src) req_reg = 1'b1; else req_pin = 1'b1;
    for (int k = 1; k <= h; k++) begin
      @(negedge clk);
      if (busy) begin ks = k; break; end
    end
    if (ef) chk(ks == HIGH_MIN, {rq, " start cycle"}, ks, HIGH_MIN);
    else    chk(ks == 0, {rq, " no start"}, ks, 0);
    if (ks != 0) begin
      measure(td, rq);
      idle_quiet(8, "R2 held high no retrigger");
    end
    pwr_down = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED_0C41));
    rst_n = 1'b0; req_pin = 1'b1; req_reg = 1'b1; src_sel = 1'b0;
    trim_dis = 1'b0; cpa_en = 1'b0; pwr_down = 1'b0; or_raw = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && dclk_en && data_valid, "R6 reset state", int'(busy), 0);

    // R6: power-up calibration after release
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy, "R6 power-up not before third edge", int'(busy), 0);
    @(negedge clk);
    chk(busy, "R6 power-up start", int'(busy), 1);
    measure(1'b0, "R6");
    idle_quiet(6, "R6 single power-up run");

    // Directed boundaries for R1
    trial(LOW_MIN - 1, HIGH_MIN + 2, 1'b0, 1'b0, 1'b0, 1'b0);
    trial(LOW_MIN, HIGH_MIN - 1, 1'b0, 1'b0, 1'b0, 1'b0);
    trial(LOW_MIN, HIGH_MIN, 1'b0, 1'b0, 1'b0, 1'b0);
    trial(LOW_MIN, HIGH_MIN, 1'b1, 1'b1, 1'b0, 1'b0);
    trial(LOW_MIN + 2, HIGH_MIN, 1'b1, 1'b0, 1'b1, 1'b0);   // R4 blocked
    trial(LOW_MIN + 2, HIGH_MIN, 1'b1, 1'b1, 1'b1, 1'b0);   // R4 allowed
    trial(LOW_MIN, HIGH_MIN + 1, 1'b0, 1'b1, 1'b0, 1'b1);   // R5 blocked

    // R2: unselected source toggled with a valid pattern
    src_sel = 1'b0; req_pin = 1'b1; req_reg = 1'b0;
    repeat (LOW_MIN + 2) @(negedge clk);
    req_reg = 1'b1;
    idle_quiet(HIGH_MIN + 4, "R2 unselected source ignored");

    // R9: full request replayed during busy is dropped
    trial(LOW_MIN, HIGH_MIN, 1'b0, 1'b0, 1'b0, 1'b0);
    src_sel = 1'b1; req_reg = 1'b1; trim_dis = 1'b0;
    req_pin = 1'b0; src_sel = 1'b0;
    repeat (LOW_MIN + 1) @(negedge clk);
    req_pin = 1'b1;
    // request above was idle-time: it fires; replay inside busy
    repeat (HIGH_MIN) @(negedge clk);
    chk(busy, "R9 setup start", int'(busy), 1);
    req_pin = 1'b0;
    repeat (LOW_MIN + 1) @(negedge clk);
    req_pin = 1'b1;
    while (busy) @(negedge clk);
    idle_quiet(10, "R9 request during busy ignored");
    trial(LOW_MIN, HIGH_MIN, 1'b0, 1'b1, 1'b0, 1'b0);       // R9 restart works

    // Random mix
    for (int i = 0; i < 60; i++)
      trial(1 + int'($urandom % 7), 1 + int'($urandom % 6), 1'($urandom % 2),
            1'($urandom % 2), 1'($urandom % 2), 1'(($urandom % 5) == 0));

    // R10: power-up calibration held by power-down
    rst_n = 1'b0; pwr_down = 1'b1; trim_dis = 1'b1; cpa_en = 1'b0;
    req_pin = 1'b1; req_reg = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle_quiet(10, "R10 power-up held in power-down");
    pwr_down = 1'b0;
    @(negedge clk);
    chk(busy, "R10 power-up after power-down", int'(busy), 1);
    measure(1'b1, "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done_flag = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule